// File: doc/BRIEF.md
# Scan-Command Debug Register Access Unit

This unit sits behind a JTAG test access port and turns data-register scans into register accesses. The TAP state machine lives outside; it presents the current 4-bit instruction together with capture, shift and update strobes in the TCK domain. Under the chain-choose instruction, a short scan picks which command chain later scans will address. Under the debug instruction, each scan is one command frame aimed at that chain. The internal-register chain uses a 5-bit address and the processor-register chain uses a 32-bit address.

Every frame carries its own 8-bit CRC. A frame whose CRC or length is wrong changes nothing and raises a frame error flag. A good frame is handed to the system clock domain through a toggle. That toggle passes a two-flop synchronizer and an edge detector. The bus sequencer there is a three-state machine. `ST_IDLE` moves to `ST_SETUP` on a detected request; in that state it latches the command and drives address and write data. `ST_SETUP` always moves to `ST_STROBE`, where one strobe pulses and read data is captured. `ST_STROBE` always returns to `ST_IDLE`. The captured read value goes out in the data field of the next debug scan.

Bits travel least significant first, and tdo is a combinational view of the bit about to be shifted. The TAP is expected to retime tdo on the falling TCK edge.

Top module: `dbgscan_cmd`

## Requirements
- R1: With ir = 4'h6 (chain choose), a 12-bit scan holds a 4-bit chain id (bits 0..3) followed by its CRC (bits 4..11). A good frame makes that id the active chain: 4'h9 is the internal-register chain and 4'h5 is the processor chain. A bad frame keeps the previous chain.
- R2: With ir = 4'hB (debug) and the internal chain active, a 46-bit frame is laid out as address[4:0] (bits 0..4), R/W (bit 5, 1 = write), data (bits 6..37) and CRC (bits 38..45). A write to a mapped address pulses reg_wr once, with bus_addr equal to the zero-extended address and bus_wdata equal to the data.
- R3: With ir = 4'hB and the processor chain active, a 73-bit frame is laid out as address (bits 0..31), R/W (bit 32), data (bits 33..64) and CRC (bits 65..72). A write pulses cpu_wr once, with that address and data.
- R4: A read frame (R/W = 0) pulses reg_rd or cpu_rd once and ignores its data field. The read data is captured and comes out on tdo in the data field of the next debug scan: bits 6..37 on the internal chain and bits 33..64 on the processor chain. That field repeats the most recent read result.
- R5: An internal address at or above REG_COUNT (default 8) has no register. Such an access produces no strobe, and a read of it makes the next scan return all zeros.
- R6: The CRC uses x^8+x^2+x+1 with seed 8'hFF over every bit before the CRC field, in shift order (MSB-first register update). The received CRC is taken LSB first. A CRC mismatch or a wrong bit count means no access and frame_err = 1. The next accepted frame clears frame_err.
- R7: Each access is a single-cycle pulse, and at most one of the four strobes is high at a time. bus_addr and bus_wdata hold the same value in the cycle before the pulse and during it. The pulse comes within 8 clk cycles after update_dr.
- R8: A debug scan while neither known chain is active, or a scan under any other instruction, makes no access and leaves frame_err unchanged.
- R9: After reset frame_err is 0, no chain is active, no strobe is high, and the held read value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System-domain reset, active low |
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-domain reset, active low |
| ir | input | 4 | Current TAP instruction |
| capture_dr | input | 1 | Capture-DR strobe from the TAP |
| shift_dr | input | 1 | Shift-DR strobe from the TAP |
| update_dr | input | 1 | Update-DR strobe from the TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit about to be shifted) |
| frame_err | output | 1 | Last frame rejected on CRC or length |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| reg_wr | output | 1 | Internal register write strobe |
| reg_rd | output | 1 | Internal register read strobe |
| reg_rdata | input | 32 | Internal register read data |
| cpu_wr | output | 1 | Processor register write strobe |
| cpu_rd | output | 1 | Processor register read strobe |
| cpu_rdata | input | 32 | Processor register read data |

## Verification
Some properties are checked on every cycle: the strobes are one-hot and last a single cycle, address and write data are stable through the setup and strobe cycles, no strobe reaches an unmapped internal address, and frame_err changes only on an update. Other behaviour can only be shown by the bench's scans. That includes the frame layouts, CRC acceptance and rejection including wrong-length frames, and chain choice surviving a bad select. It also includes read data coming back one scan later, unmapped reads returning zeros, and ignored scans under other instructions or chains. The bench compares each strobe against a queue of expected accesses on every clock.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
    localparam int IR_W     = 4;
    localparam int CHAIN_W  = 4;
    localparam int CRC_W    = 8;
    localparam int DATA_W   = 32;
    localparam int RADDR_W  = 5;
    localparam int CADDR_W  = 32;
    // payload lengths (bits before the CRC field)
    localparam int CSEL_PAY = CHAIN_W;
    localparam int REG_PAY  = RADDR_W + 1 + DATA_W;
    localparam int CPU_PAY  = CADDR_W + 1 + DATA_W;
    localparam int MAX_LEN  = CPU_PAY + CRC_W;
    localparam int CNT_W    = $clog2(MAX_LEN + 2);
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam logic [CRC_W-1:0] CRC_SEED = 8'hFF;

    typedef enum logic [1:0] {MODE_IDLE, MODE_CSEL, MODE_REGS, MODE_CPU} scan_mode_t;
    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE} seq_state_t;

    typedef struct packed {
        logic               cpu;
        logic               wr;
        logic [CADDR_W-1:0] addr;
        logic [DATA_W-1:0]  data;
    } acc_cmd_t;
endpackage

// File: rtl/dbg_crc8_ser.sv
module dbg_crc8_ser
    import dbg_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic fb;
    assign fb = crc[CRC_W-1] ^ din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      crc <= CRC_SEED;
        else if (clear)  crc <= CRC_SEED;
        else if (en)     crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
endmodule

// File: rtl/dbg_scan_decoder.sv
module dbg_scan_decoder
    import dbg_cmd_pkg::*;
#(
    parameter logic [IR_W-1:0]    IR_CHAINSEL = 4'h6,
    parameter logic [IR_W-1:0]    IR_DEBUG    = 4'hB,
    parameter logic [CHAIN_W-1:0] CHAIN_REGS  = 4'h9,
    parameter logic [CHAIN_W-1:0] CHAIN_CPU   = 4'h5
)(
    input  logic              tck,
    input  logic              trst_n,
    input  logic [IR_W-1:0]   ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    input  logic [DATA_W-1:0] rd_hold,
    output logic              tdo,
    output logic              frame_err,
    output logic              req_tgl,
    output acc_cmd_t          cmd
);
    localparam logic [CNT_W-1:0] LEN_C = CNT_W'(MAX_LEN);
    localparam logic [CNT_W-1:0] SAT_C = CNT_W'(MAX_LEN + 1);

    logic [MAX_LEN-1:0] dr;
    logic [CNT_W-1:0]   cnt, plen, flen;
    logic [CHAIN_W-1:0] chain_q;
    logic [CRC_W-1:0]   crc_calc;
    logic               crc_ok;
    scan_mode_t         mode;

    always_comb begin
        mode = MODE_IDLE;
        if (ir == IR_CHAINSEL)                          mode = MODE_CSEL;
        else if (ir == IR_DEBUG && chain_q == CHAIN_REGS) mode = MODE_REGS;
        else if (ir == IR_DEBUG && chain_q == CHAIN_CPU)  mode = MODE_CPU;
    end

    always_comb begin
        unique case (mode)
            MODE_CSEL: plen = CNT_W'(CSEL_PAY);
            MODE_REGS: plen = CNT_W'(REG_PAY);
            MODE_CPU:  plen = CNT_W'(CPU_PAY);
            default:   plen = '0;
        endcase
    end
    assign flen = plen + CNT_W'(CRC_W);

    dbg_crc8_ser u_crc (
        .clk   (tck),
        .rst_n (trst_n),
        .clear (capture_dr),
        .en    (shift_dr && (cnt < plen)),
        .din   (tdi),
        .crc   (crc_calc)
    );

    // shift register written by bit index; saturating bit counter
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            dr  <= '0;
            cnt <= '0;
        end else if (capture_dr) begin
            dr  <= '0;
            cnt <= '0;
            if (mode == MODE_REGS)     dr[RADDR_W+1 +: DATA_W] <= rd_hold;
            else if (mode == MODE_CPU) dr[CADDR_W+1 +: DATA_W] <= rd_hold;
        end else if (shift_dr) begin
            if (cnt < LEN_C)  dr[cnt] <= tdi;
            if (cnt != SAT_C) cnt     <= cnt + 1'b1;
        end
    end

    assign tdo    = (cnt < LEN_C) ? dr[cnt] : 1'b0;
    assign crc_ok = (cnt == flen) && (dr[plen +: CRC_W] == crc_calc);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            chain_q   <= '0;
            frame_err <= 1'b0;
            req_tgl   <= 1'b0;
            cmd       <= '0;
        end else if (update_dr && mode != MODE_IDLE) begin
            if (!crc_ok) begin
                frame_err <= 1'b1;
            end else begin
                frame_err <= 1'b0;
                unique case (mode)
                    MODE_CSEL: chain_q <= dr[CHAIN_W-1:0];
                    MODE_REGS: begin
                        cmd.cpu  <= 1'b0;
                        cmd.wr   <= dr[RADDR_W];
                        cmd.addr <= CADDR_W'(dr[RADDR_W-1:0]);
                        cmd.data <= dr[RADDR_W+1 +: DATA_W];
                        req_tgl  <= ~req_tgl;
                    end
                    MODE_CPU: begin
                        cmd.cpu  <= 1'b1;
                        cmd.wr   <= dr[CADDR_W];
                        cmd.addr <= dr[CADDR_W-1:0];
                        cmd.data <= dr[CADDR_W+1 +: DATA_W];
                        req_tgl  <= ~req_tgl;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dbg_bus_sequencer.sv
module dbg_bus_sequencer
    import dbg_cmd_pkg::*;
#(
    parameter int REG_COUNT = 8
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_tgl,
    input  acc_cmd_t           cmd,
    input  logic [DATA_W-1:0]  reg_rdata,
    input  logic [DATA_W-1:0]  cpu_rdata,
    output logic [CADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               reg_wr,
    output logic               reg_rd,
    output logic               cpu_wr,
    output logic               cpu_rd,
    output logic [DATA_W-1:0]  rd_hold
);
    logic [2:0] sync_q;
    logic       req_edge, mapped, strobe_on;
    seq_state_t state, state_nx;
    acc_cmd_t   lat;

    // two synchronizing flops plus one for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], req_tgl};
    end
    assign req_edge = sync_q[2] ^ sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = req_edge ? ST_SETUP : ST_IDLE;
            ST_SETUP:  state_nx = ST_STROBE;
            ST_STROBE: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat     <= '0;
            rd_hold <= '0;
        end else begin
            if (state == ST_IDLE && req_edge) lat <= cmd;
            if (state == ST_STROBE && !lat.wr)
                rd_hold <= lat.cpu ? cpu_rdata : (mapped ? reg_rdata : '0);
        end
    end

    assign mapped    = lat.cpu || (lat.addr < CADDR_W'(REG_COUNT));
    assign strobe_on = (state == ST_STROBE) && mapped;
    assign reg_wr    = strobe_on && !lat.cpu &&  lat.wr;
    assign reg_rd    = strobe_on && !lat.cpu && !lat.wr;
    assign cpu_wr    = strobe_on &&  lat.cpu &&  lat.wr;
    assign cpu_rd    = strobe_on &&  lat.cpu && !lat.wr;
    assign bus_addr  = lat.addr;
    assign bus_wdata = lat.data;
endmodule

// File: rtl/dbgscan_cmd.sv
module dbgscan_cmd
    import dbg_cmd_pkg::*;
#(
    parameter int REG_COUNT = 8
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tck,
    input  logic               trst_n,
    input  logic [IR_W-1:0]    ir,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    output logic               tdo,
    output logic               frame_err,
    output logic [CADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               reg_wr,
    output logic               reg_rd,
    input  logic [DATA_W-1:0]  reg_rdata,
    output logic               cpu_wr,
    output logic               cpu_rd,
    input  logic [DATA_W-1:0]  cpu_rdata
);
    logic              req_tgl;
    acc_cmd_t          cmd;
    logic [DATA_W-1:0] rd_hold;

    dbg_scan_decoder u_dec (
        .tck        (tck),
        .trst_n     (trst_n),
        .ir         (ir),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .rd_hold    (rd_hold),
        .tdo        (tdo),
        .frame_err  (frame_err),
        .req_tgl    (req_tgl),
        .cmd        (cmd)
    );

    dbg_bus_sequencer #(.REG_COUNT(REG_COUNT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_tgl   (req_tgl),
        .cmd       (cmd),
        .reg_rdata (reg_rdata),
        .cpu_rdata (cpu_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .rd_hold   (rd_hold)
    );
endmodule

// File: rtl/dbgscan_cmd_chk.sv
module dbgscan_cmd_chk #(
    parameter int REG_COUNT = 8
)(
    input logic        clk,
    input logic        rst_n,
    input logic        tck,
    input logic        trst_n,
    input logic        update_dr,
    input logic        frame_err,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic        cpu_wr,
    input logic        cpu_rd
);
    logic any_strobe;
    assign any_strobe = reg_wr | reg_rd | cpu_wr | cpu_rd;

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd, cpu_wr, cpu_rd}));

    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> !any_strobe);

    assert_bus_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> ($stable(bus_addr) && $stable(bus_wdata)));

    assert_mapped_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr | reg_rd) |-> (bus_addr < 32'(REG_COUNT)));

    assert_reg_addr_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr | reg_rd) |-> (bus_addr[31:5] == '0));

    assert_err_on_update_R6: assert property (@(posedge tck) disable iff (!trst_n)
        !update_dr |=> $stable(frame_err));
endmodule

bind dbgscan_cmd dbgscan_cmd_chk #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tck       (tck),
    .trst_n    (trst_n),
    .update_dr (update_dr),
    .frame_err (frame_err),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd)
);

// File: tb/sim_dbgscan_cmd.sv
module sim_dbgscan_cmd;
    logic        clk = 0, rst_n = 0, tck = 0, trst_n = 0;
    logic [3:0]  ir = 4'h0;
    logic        capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic        tdo, frame_err, reg_wr, reg_rd, cpu_wr, cpu_rd;
    logic [31:0] bus_addr, bus_wdata, reg_rdata, cpu_rdata;

    int nchk = 0, nerr = 0;
    logic [65:0] exp_q[$];
    logic [31:0] exp_rd = 32'h0;
    logic [31:0] prev_addr = 32'h0, prev_wdata = 32'h0;
    int clk_since_upd = 0;

    always #4 clk = ~clk;
    always #32 tck = ~tck;

    assign reg_rdata = {16'hC0DE, 11'd0, bus_addr[4:0]};
    assign cpu_rdata = bus_addr ^ 32'hFFFF_0000;

    dbgscan_cmd u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [72:0] b, input int n);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < n; i++) begin
            logic fb = c[7] ^ b[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    function automatic logic [72:0] mk_csel(input logic [3:0] id);
        logic [72:0] f = '0;
        f[3:0] = id;
        f[11:4] = ref_crc(f, 4);
        return f;
    endfunction

    function automatic logic [72:0] mk_reg(input logic [4:0] a, input logic wr, input logic [31:0] d);
        logic [72:0] f = '0;
        f[4:0] = a; f[5] = wr; f[37:6] = d;
        f[45:38] = ref_crc(f, 38);
        return f;
    endfunction

    function automatic logic [72:0] mk_cpu(input logic [31:0] a, input logic wr, input logic [31:0] d);
        logic [72:0] f = '0;
        f[31:0] = a; f[32] = wr; f[64:33] = d;
        f[72:65] = ref_crc(f, 65);
        return f;
    endfunction

    task automatic do_scan(input int len, input logic [72:0] bits, output logic [72:0] got);
        got = '0;
        @(negedge tck); capture_dr = 1;
        @(negedge tck); capture_dr = 0;
        for (int i = 0; i < len; i++) begin
            got[i] = tdo;
            shift_dr = 1; tdi = bits[i];
            @(negedge tck);
        end
        shift_dr = 0; update_dr = 1;
        @(negedge tck); update_dr = 0;
        repeat (3) @(negedge tck);
    endtask

    // debug scan on internal chain; checks returned read field, updates model
    task automatic reg_cmd(input logic [4:0] a, input logic wr, input logic [31:0] d, input string req);
        logic [72:0] got;
        if (a < 8) exp_q.push_back({1'b0, wr, 27'd0, a, d});
        do_scan(46, mk_reg(a, wr, d), got);
        chk(got[37:6] === exp_rd, "R4", "internal chain read field", 64'(got[37:6]), 64'(exp_rd));
        if (!wr) exp_rd = (a < 8) ? {16'hC0DE, 11'd0, a} : 32'h0;
        chk(exp_q.size() == 0, req, "internal access issued", 64'(exp_q.size()), 64'd0);
        chk(frame_err === 1'b0, req, "frame_err after good frame", 64'(frame_err), 64'd0);
    endtask

    task automatic cpu_cmd(input logic [31:0] a, input logic wr, input logic [31:0] d, input string req);
        logic [72:0] got;
        exp_q.push_back({1'b1, wr, a, d});
        do_scan(73, mk_cpu(a, wr, d), got);
        chk(got[64:33] === exp_rd, "R4", "processor chain read field", 64'(got[64:33]), 64'(exp_rd));
        if (!wr) exp_rd = a ^ 32'hFFFF_0000;
        chk(exp_q.size() == 0, req, "processor access issued", 64'(exp_q.size()), 64'd0);
    endtask

    // reference comparison of every strobe, every clock
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0]  s;
            logic [65:0] e;
            clk_since_upd++;
            s = {reg_wr, reg_rd, cpu_wr, cpu_rd};
            if (|s) begin
                chk(clk_since_upd <= 8, "R7", "strobe latency", 64'(clk_since_upd), 64'd8);
                chk(bus_addr === prev_addr && bus_wdata === prev_wdata, "R7",
                    "address setup before strobe", 64'(bus_addr), 64'(prev_addr));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected strobe", 64'(s), 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk((cpu_wr | cpu_rd) === e[65] && (reg_wr | cpu_wr) === e[64], "R2",
                        "strobe kind", 64'(s), 64'(e[65:64]));
                    chk(bus_addr === e[63:32], "R3", "access address", 64'(bus_addr), 64'(e[63:32]));
                    if (e[64])
                        chk(bus_wdata === e[31:0], "R2", "write data", 64'(bus_wdata), 64'(e[31:0]));
                end
            end
            prev_addr  = bus_addr;
            prev_wdata = bus_wdata;
        end
    end
    always @(posedge tck) if (update_dr) clk_since_upd = 0;

    initial begin
        #1_000_000;
        chk(1'b0, "R9", "watchdog expired", 64'd0, 64'd1);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [72:0] got, f;
        repeat (3) @(negedge tck);
        rst_n = 1; trst_n = 1;
        @(negedge tck);
        // R9 reset state
        chk(frame_err === 1'b0, "R9", "frame_err after reset", 64'(frame_err), 64'd0);
        chk({reg_wr, reg_rd, cpu_wr, cpu_rd} === 4'b0, "R9", "strobes after reset",
            64'({reg_wr, reg_rd, cpu_wr, cpu_rd}), 64'd0);
        // R8: no chain chosen yet, debug frame ignored
        ir = 4'hB;
        do_scan(46, mk_reg(5'd1, 1'b1, 32'h1111_2222), got);
        chk(frame_err === 1'b0, "R8", "no chain: frame_err unchanged", 64'(frame_err), 64'd0);
        // R1 choose internal chain
        ir = 4'h6;
        do_scan(12, mk_csel(4'h9), got);
        chk(frame_err === 1'b0, "R1", "good chain choose", 64'(frame_err), 64'd0);
        ir = 4'hB;
        reg_cmd(5'd3, 1'b1, 32'hDEAD_BEEF, "R2");
        reg_cmd(5'd7, 1'b1, 32'h0000_0001, "R2");
        reg_cmd(5'd5, 1'b0, 32'hFFFF_FFFF, "R4");     // data ignored on read
        reg_cmd(5'd0, 1'b0, 32'h0, "R4");             // returns addr 5 data
        reg_cmd(5'd20, 1'b0, 32'h0, "R5");            // unmapped read, returns addr 0 data
        reg_cmd(5'd31, 1'b1, 32'hABCD_0000, "R5");    // unmapped write, returns zeros
        reg_cmd(5'd2, 1'b1, 32'h0, "R5");             // returns zeros still
        // R6 bad CRC
        f = mk_reg(5'd4, 1'b1, 32'h5555_5555); f[40] = ~f[40];
        do_scan(46, f, got);
        chk(frame_err === 1'b1, "R6", "bad CRC flagged", 64'(frame_err), 64'd1);
        chk(exp_q.size() == 0, "R6", "bad CRC no access", 64'(exp_q.size()), 64'd0);
        // R6 short frame
        do_scan(45, mk_reg(5'd4, 1'b1, 32'h5555_5555), got);
        chk(frame_err === 1'b1, "R6", "short frame flagged", 64'(frame_err), 64'd1);
        // R8 other instruction: frame_err kept, no access
        ir = 4'h1;
        do_scan(46, mk_reg(5'd4, 1'b1, 32'h7777_7777), got);
        chk(frame_err === 1'b1, "R8", "other instruction ignored", 64'(frame_err), 64'd1);
        ir = 4'hB;
        reg_cmd(5'd4, 1'b1, 32'h1234_5678, "R6");     // clears error
        // R1 bad chain choose keeps internal chain
        ir = 4'h6;
        f = mk_csel(4'h5); f[6] = ~f[6];
        do_scan(12, f, got);
        chk(frame_err === 1'b1, "R1", "bad chain choose flagged", 64'(frame_err), 64'd1);
        ir = 4'hB;
        reg_cmd(5'd6, 1'b1, 32'h0BAD_F00D, "R1");
        // R3 processor chain
        ir = 4'h6;
        do_scan(12, mk_csel(4'h5), got);
        ir = 4'hB;
        cpu_cmd(32'h8000_1234, 1'b1, 32'hCAFE_BABE, "R3");
        cpu_cmd(32'h0000_00F0, 1'b0, 32'h9999_9999, "R3");
        cpu_cmd(32'hFFFF_FFFC, 1'b0, 32'h0, "R4");
        cpu_cmd(32'h0000_0010, 1'b1, 32'h0000_0042, "R3");
        // R8 unknown chain
        ir = 4'h6;
        do_scan(12, mk_csel(4'h7), got);
        ir = 4'hB;
        do_scan(73, mk_cpu(32'h1, 1'b1, 32'h2), got);
        do_scan(46, mk_reg(5'd1, 1'b1, 32'h3), got);
        chk(frame_err === 1'b0, "R8", "unknown chain ignored", 64'(frame_err), 64'd0);
        chk(exp_q.size() == 0, "R8", "unknown chain no access", 64'(exp_q.size()), 64'd0);
        repeat (4) @(negedge tck);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule